// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Monitor

This block runs the link test state machine of a twisted-pair transceiver on already-digitized events. A front end outside the block turns the analog line into single-cycle strobes: one for a qualified positive link pulse and one for a qualified negative link pulse. It also supplies a level that is high while receive data is active. The monitor decides whether the link is working. It gates the transmit, receive, loopback and collision-detect paths to match that decision. It flags a transmit attempted on a dead link, and it asks the line driver for idle link pulses at a fixed interval.

After reset the link is considered failed. It becomes usable after valid receive data, or after a run of pulses that all share one polarity and is longer than five. While the link is usable, a long enough silence with no pulses and no data drops it back to failed. A disable control keeps the datapath open for partners that send no link pulses. Pulse generation continues no matter how that control is set. The loss window and the pulse interval are cycle-count parameters, so a simulation can shrink the 50–150 ms and 16 ms figures.

Top module: `tp_link_monitor`

## Requirements
- R1: While reset is active and just after it is released, `link_ok_o` is 0, both error strobes are 0, and with `lt_disable_i` low all four path enables are 0.
- R2: In the failed state, `RUN_NEEDED` (default 6) consecutive strobes of one polarity set `link_ok_o` in the cycle after the clock edge that samples the last of them. Five are not enough.
- R3: A strobe whose polarity differs from the run in progress restarts the count at one, with the new polarity. Both strobes in the same cycle clear the count to zero.
- R4: In the failed state, runs of negative strobes qualify exactly as runs of positive strobes do.
- R5: In the failed state, `rx_active_i` high at a clock edge sets `link_ok_o` after that edge.
- R6: In the passed state with `lt_disable_i` low, the link fails on the `LOSS_CYCLES`-th consecutive edge that samples no strobe and no `rx_active_i`. Any strobe or receive activity restarts that window, including activity on the edge where the window would have expired.
- R7: With `lt_disable_i` low, `tx_en_o`, `rx_en_o`, `lb_en_o` and `col_en_o` each equal `link_ok_o`.
- R8: `tx_req_i` sampled while the path is closed (failed state and `lt_disable_i` low) raises both `lost_carrier_o` and `col_err_o` for the following cycle, and `tx_en_o` stays 0. A request while the path is open raises neither.
- R9: With `lt_disable_i` high, all four enables are 1, no error strobe fires, and no loss timeout occurs in the passed state.
- R10: While `tx_idle_i` is high, `lp_send_o` pulses for one cycle after every `IDLE_CYCLES`-th consecutive idle edge, whatever `lt_disable_i` is. A low `tx_idle_i` restarts the interval and suppresses the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_pos_i | input | 1 | Qualified positive link pulse strobe |
| lp_neg_i | input | 1 | Qualified negative link pulse strobe |
| rx_active_i | input | 1 | Valid receive data present |
| tx_idle_i | input | 1 | Transmit pair idle |
| lt_disable_i | input | 1 | Link test disable |
| tx_req_i | input | 1 | Transmit request |
| link_ok_o | output | 1 | Link status, 1 when passed |
| tx_en_o | output | 1 | Transmit path enable |
| rx_en_o | output | 1 | Receive path enable |
| lb_en_o | output | 1 | Loopback enable |
| col_en_o | output | 1 | Collision detect enable |
| lost_carrier_o | output | 1 | Lost-carrier error strobe |
| col_err_o | output | 1 | Collision-error strobe |
| lp_send_o | output | 1 | Request to emit one link pulse |

## Verification
Two functions can land in the same cycle. The run that qualifies the link can complete on the same edge that samples a transmit request, and receive activity can arrive on the exact edge where the loss window would expire. The bench sets up both. In the first case, the edge that completes a sixth negative strobe also samples a request. The bench expects the link to pass and the error pair to fire, because the path was still closed when the request was sampled. In the second case, it counts `LOSS_CYCLES-1` quiet edges and then drives receive activity on the next one. It judges that the link stays up, and then that it falls exactly after a fresh full window.

// File: rtl/tp_link_pkg.sv
package tp_link_pkg;
  typedef enum logic {
    LNK_DOWN = 1'b0,
    LNK_UP   = 1'b1
  } lnk_state_t;
endpackage

// File: rtl/tp_pulse_run.sv
module tp_pulse_run #(
  parameter int RUN_NEEDED = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear_i,
  input  logic pos_i,
  input  logic neg_i,
  output logic done_o
);
  localparam int CW = $clog2(RUN_NEEDED + 1);

  logic [CW-1:0] run_q, run_d;
  logic          pol_q, pol_d;   // 1 = negative run
  logic          hit;

  always_comb begin
    run_d = run_q;
    pol_d = pol_q;
    hit   = 1'b0;
    if (clear_i) begin
      run_d = '0;
    end else if (pos_i && neg_i) begin
      run_d = '0;
    end else if (pos_i || neg_i) begin
      pol_d = neg_i;
      if ((run_q != '0) && (neg_i == pol_q) && (run_q < CW'(RUN_NEEDED)))
        run_d = run_q + 1'b1;
      else
        run_d = CW'(1);
      hit = (run_d == CW'(RUN_NEEDED));
    end
  end

  assign done_o = hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      pol_q <= 1'b0;
    end else begin
      run_q <= run_d;
      pol_q <= pol_d;
    end
  end

  a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= CW'(RUN_NEEDED));

  a_r3_clash_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (pos_i && neg_i) |=> (run_q == '0));
endmodule

// File: rtl/tp_loss_timer.sv
module tp_loss_timer #(
  parameter int LOSS_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic kick_i,
  output logic expire_o
);
  localparam int TW = $clog2(LOSS_CYCLES);
  localparam logic [TW-1:0] LAST = TW'(LOSS_CYCLES - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          fire;

  always_comb begin
    fire  = run_i && !kick_i && (cnt_q == LAST);
    cnt_d = cnt_q;
    if (!run_i || kick_i || fire)
      cnt_d = '0;
    else
      cnt_d = cnt_q + 1'b1;
  end

  assign expire_o = fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  a_r6_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  a_r6_kick_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> (cnt_q == '0));
endmodule

// File: rtl/tp_idle_pulser.sv
module tp_idle_pulser #(
  parameter int IDLE_CYCLES = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic idle_i,
  output logic send_o
);
  localparam int PW = $clog2(IDLE_CYCLES);
  localparam logic [PW-1:0] LAST = PW'(IDLE_CYCLES - 1);

  logic [PW-1:0] gap_q, gap_d;
  logic          send_q, send_d;

  always_comb begin
    send_d = idle_i && (gap_q == LAST);
    if (!idle_i || send_d) gap_d = '0;
    else                   gap_d = gap_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      send_q <= 1'b0;
    end else begin
      gap_q  <= gap_d;
      send_q <= send_d;
    end
  end

  assign send_o = send_q;

  a_r10_needs_idle: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |-> $past(idle_i));

  a_r10_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    send_o |=> !send_o);
endmodule

// File: rtl/tp_link_monitor.sv
module tp_link_monitor #(
  parameter int RUN_NEEDED  = 6,
  parameter int LOSS_CYCLES = 1000,
  parameter int IDLE_CYCLES = 320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lp_pos_i,
  input  logic lp_neg_i,
  input  logic rx_active_i,
  input  logic tx_idle_i,
  input  logic lt_disable_i,
  input  logic tx_req_i,
  output logic link_ok_o,
  output logic tx_en_o,
  output logic rx_en_o,
  output logic lb_en_o,
  output logic col_en_o,
  output logic lost_carrier_o,
  output logic col_err_o,
  output logic lp_send_o
);
  import tp_link_pkg::*;

  lnk_state_t st_q, st_d;
  logic run_done, loss_fire, activity, path_open;
  logic lcar_q, lcar_d, cerr_q, cerr_d;

  assign activity  = lp_pos_i || lp_neg_i || rx_active_i;
  assign path_open = (st_q == LNK_UP) || lt_disable_i;

  tp_pulse_run #(.RUN_NEEDED(RUN_NEEDED)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear_i (st_q == LNK_UP),
    .pos_i   (lp_pos_i),
    .neg_i   (lp_neg_i),
    .done_o  (run_done)
  );

  tp_loss_timer #(.LOSS_CYCLES(LOSS_CYCLES)) u_loss (
    .clk      (clk),
    .rst_n    (rst_n),
    .run_i    ((st_q == LNK_UP) && !lt_disable_i),
    .kick_i   (activity),
    .expire_o (loss_fire)
  );

  tp_idle_pulser #(.IDLE_CYCLES(IDLE_CYCLES)) u_beat (
    .clk    (clk),
    .rst_n  (rst_n),
    .idle_i (tx_idle_i),
    .send_o (lp_send_o)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      LNK_DOWN: if (rx_active_i || run_done) st_d = LNK_UP;
      LNK_UP:   if (loss_fire)               st_d = LNK_DOWN;
      default:  st_d = LNK_DOWN;
    endcase
    lcar_d = tx_req_i && !path_open;
    cerr_d = tx_req_i && !path_open;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= LNK_DOWN;
      lcar_q <= 1'b0;
      cerr_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      lcar_q <= lcar_d;
      cerr_q <= cerr_d;
    end
  end

  assign link_ok_o      = (st_q == LNK_UP);
  assign tx_en_o        = path_open;
  assign rx_en_o        = path_open;
  assign lb_en_o        = path_open;
  assign col_en_o       = path_open;
  assign lost_carrier_o = lcar_q;
  assign col_err_o      = cerr_q;

  a_r2_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(link_ok_o) |-> ($past(rx_active_i) || $past(lp_pos_i) || $past(lp_neg_i)));

  a_r6_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_ok_o) |-> (!$past(activity) && !$past(lt_disable_i)));

  a_r8_error_cause: assert property (@(posedge clk) disable iff (!rst_n)
    lost_carrier_o |-> ($past(tx_req_i) && !$past(link_ok_o) && !$past(lt_disable_i)));

  a_r8_pair_together: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_req_i && !path_open) |=> (lost_carrier_o && col_err_o));
endmodule

// File: tb/tp_link_monitor_bench.sv
`timescale 1ns/1ps
module tp_link_monitor_bench;
  localparam int RUN  = 6;
  localparam int LOSS = 20;
  localparam int IDLE = 12;
  localparam int NV   = 12;
  // {pos, neg, rx, txreq, exp_link, exp_err}
  localparam logic [5:0] VEC [NV] = '{
    6'b100000, 6'b100000, 6'b100000, 6'b100000, 6'b100000,
    6'b010000, 6'b010000, 6'b010000, 6'b010000, 6'b010000,
    6'b010111, 6'b000110
  };

  logic clk = 1'b0;
  logic rst_n, lp_pos, lp_neg, rx_act, tx_idle, lt_dis, tx_req;
  logic link_ok, tx_en, rx_en, lb_en, col_en, lcar, cerr, lp_send;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  tp_link_monitor #(.RUN_NEEDED(RUN), .LOSS_CYCLES(LOSS), .IDLE_CYCLES(IDLE)) u_tp_link_monitor (
    .clk(clk), .rst_n(rst_n), .lp_pos_i(lp_pos), .lp_neg_i(lp_neg),
    .rx_active_i(rx_act), .tx_idle_i(tx_idle), .lt_disable_i(lt_dis),
    .tx_req_i(tx_req), .link_ok_o(link_ok), .tx_en_o(tx_en), .rx_en_o(rx_en),
    .lb_en_o(lb_en), .col_en_o(col_en), .lost_carrier_o(lcar),
    .col_err_o(cerr), .lp_send_o(lp_send)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    lp_pos = 0; lp_neg = 0; rx_act = 0; tx_req = 0;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    quiet(); tx_idle = 0; lt_dis = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(5.0 * 20000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 link", link_ok, 0);
    chk("R1 enables", {tx_en, rx_en, lb_en, col_en}, 4'b0000);
    chk("R1 errors", {lcar, cerr}, 2'b00);

    // R2 R3 R4 R8 vector walk
    for (int i = 0; i < NV; i++) begin
      {lp_pos, lp_neg, rx_act, tx_req} = VEC[i][5:2];
      step();
      chk($sformatf("R2/R3/R4 link vec%0d", i), link_ok, VEC[i][1]);
      chk($sformatf("R8 errors vec%0d", i), {lcar, cerr}, {2{VEC[i][0]}});
      chk($sformatf("R10 no beat vec%0d", i), lp_send, 0);
    end
    quiet();

    // R6 timeout with activity on the expiry edge
    rx_act = 1; step(); quiet();
    repeat (LOSS - 1) step();
    chk("R6 up before window end", link_ok, 1);
    rx_act = 1; step(); quiet();
    chk("R6 activity on expiry edge keeps link", link_ok, 1);
    repeat (LOSS - 1) step();
    chk("R6 up one edge early", link_ok, 1);
    step();
    chk("R6 link lost", link_ok, 0);
    chk("R7 enables follow down", {tx_en, rx_en, lb_en, col_en}, 4'b0000);

    // R8 transmit while down
    tx_req = 1;
    #1 chk("R8 tx_en low", tx_en, 0);
    step(); quiet();
    chk("R8 error pair", {lcar, cerr}, 2'b11);
    step();
    chk("R8 error one cycle", {lcar, cerr}, 2'b00);

    // R5 data restores link
    rx_act = 1; step(); quiet();
    chk("R5 data passes link", link_ok, 1);
    chk("R7 enables follow up", {tx_en, rx_en, lb_en, col_en}, 4'b1111);

    // R3 clash clears the run
    do_reset();
    lp_pos = 1; repeat (5) step();
    lp_neg = 1; step();
    lp_neg = 0; repeat (5) step();
    chk("R3 clash restarts run", link_ok, 0);
    step(); quiet();
    chk("R3 full run after clash", link_ok, 1);

    // R9 disable holds path open
    do_reset();
    lt_dis = 1;
    #1 chk("R9 enables forced", {tx_en, rx_en, lb_en, col_en}, 4'b1111);
    chk("R9 link still down", link_ok, 0);
    tx_req = 1; step(); quiet();
    chk("R9 no errors", {lcar, cerr}, 2'b00);
    lp_pos = 1; repeat (RUN) step(); quiet();
    chk("R9 run still passes", link_ok, 1);
    repeat (LOSS + 5) step();
    chk("R9 no timeout", link_ok, 1);

    // R10 beat interval with disable high
    tx_idle = 0; step();
    tx_idle = 1;
    for (int k = 1; k <= IDLE + 1; k++) begin
      step();
      chk($sformatf("R10 beat edge%0d", k), lp_send, (k == IDLE));
    end
    repeat (IDLE - 2) step();
    chk("R10 second beat pending", lp_send, 0);
    step();
    chk("R10 second beat", lp_send, 1);
    tx_idle = 0; step();
    chk("R10 idle drop", lp_send, 0);

    finish_run();
  end
endmodule